// File: doc/BRIEF.md
# Configurable asynchronous serial receiver

This block turns an asynchronous serial line into parallel characters. A baud divider outside the block supplies a one-cycle tick sixteen times per bit period. The receiver waits for the line to fall, confirms the start bit at its centre and samples every later bit at its centre. It strips the start, parity and stop bits and hands the data bits over on a valid/ready interface. Four per-character flags travel with the data: parity error, framing error, line break and overrun.

The character format is set by static inputs. They select the number of data bits (5 to 8), the parity mode (none, even or odd) and the number of stop bits (one or two). A short low pulse that has gone by the time the start bit is checked is dropped. A line held low for a whole character is reported once as a break. After that, nothing is received until the line has gone high again.

One output holding stage sits between the framer and the consumer. A character that completes while the previous one is still waiting replaces it, and the overrun flag is set on the new one.

Top module: `async_char_rx`

## Requirements
- R1: After reset, out_valid, out_perr, out_ferr, out_brk and out_ovr are all 0 and no character is presented until a frame is received.
- R2: The receiver advances only on cycles where tick16 is 1. It seeks a start bit on each tick after the 2-stage input synchronizer. It confirms the start bit 8 ticks after the tick that saw the line low. Each later bit is sampled 16 ticks after the previous sample. out_valid rises two clock cycles after the tick that sampled the last stop bit.
- R3: The data length is cfg_len + 5 bits (00 = 5, 01 = 6, 10 = 7, 11 = 8). Data bits arrive least significant first, bit 0 of out_data being the first data bit after the start bit. Bits of out_data at or above the length read 0.
- R4: cfg_par selects the parity: 00 or 11 = none (no parity bit is expected, out_perr is 0), 01 = even, 10 = odd. The parity bit follows the last data bit. out_perr is 1 when the data bits and the parity bit hold an odd count of ones in even mode, or an even count in odd mode.
- R5: If the synchronized line is high when the start bit is confirmed, the start is dropped, no character is produced and the receiver seeks a new start.
- R6: cfg_stop2 = 0 expects one stop bit and cfg_stop2 = 1 expects two. out_ferr is 1 if any expected stop bit is sampled low.
- R7: A character whose start, data, parity and stop samples are all low is a break. It is delivered with out_brk = 1, out_ferr = 1 and out_data = 0.
- R8: After a break, no new start bit is accepted until the line has been sampled high on a tick.
- R9: If a character completes while out_valid is 1 and out_ready is 0, the new character replaces the held one and out_ovr is 1. Otherwise out_ovr is 0 on the new character.
- R10: A presented character stays on out_valid with a stable payload until out_ready is 1 at a clock edge, or until an overrun replaces it. The handshake at that edge consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length select, length = cfg_len + 5 |
| cfg_par | input | 2 | Parity select: 00/11 none, 01 even, 10 odd |
| cfg_stop2 | input | 1 | 1 = two stop bits expected |
| out_ready | input | 1 | Consumer accepts the presented character |
| out_valid | output | 1 | A character is presented |
| out_data | output | 8 | Received data bits, upper bits zero |
| out_perr | output | 1 | Parity error on this character |
| out_ferr | output | 1 | Framing error on this character |
| out_brk | output | 1 | Character was a line break |
| out_ovr | output | 1 | Previous unread character was replaced |

## Verification
The bound checker watches the output handshake on every cycle. It checks that a waiting character holds with a stable payload, that unused upper data bits stay zero for the chosen length, and that a break always carries a framing error and zero data. It also checks that the overrun flag appears only over a character that was still valid, that no parity error appears with parity off, and that a new character follows a tick. Sample timing, false-start rejection, the parity and stop-bit checks, and the refusal to restart after a break can only be shown by driving whole frames. The bench does this against a behavioural model that counts ticks from each detected start edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int DATA_W  = 8;
   localparam int MIN_LEN = 5;

   typedef struct packed {
      logic [DATA_W-1:0] data;
      logic              perr;
      logic              ferr;
      logic              brk;
   } srx_char_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRKW
   } srx_state_e;

   function automatic logic par_enabled(input logic [1:0] sel);
      return (sel == 2'b01) || (sel == 2'b10);
   endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] cfg_len,
   input  logic [1:0] cfg_par,
   input  logic       cfg_stop2,
   output logic       done,
   output srx_char_t  chr
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] MID_C  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

   srx_state_e       state;
   logic [CW-1:0]    cnt;
   logic [2:0]       bidx;
   logic [DATA_W-1:0] sh;
   logic             pbit;
   logic             stop_idx;
   logic             stop_bad;
   logic             all_low;

   logic [2:0] last_idx;
   logic       par_on;
   logic       par_odd;
   logic       at_sample;
   logic       final_stop;

   assign last_idx   = {1'b0, cfg_len} + 3'(MIN_LEN - 1);
   assign par_on     = par_enabled(cfg_par);
   assign par_odd    = (cfg_par == 2'b10);
   assign at_sample  = (cnt == LAST_C);
   assign final_stop = (stop_idx == cfg_stop2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         sh       <= '0;
         pbit     <= 1'b0;
         stop_idx <= 1'b0;
         stop_bad <= 1'b0;
         all_low  <= 1'b0;
         done     <= 1'b0;
         chr      <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               ST_IDLE: begin
                  if (!rx) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == MID_C) begin
                     if (rx) begin
                        state <= ST_IDLE;
                     end else begin
                        state    <= ST_DATA;
                        cnt      <= '0;
                        bidx     <= '0;
                        sh       <= '0;
                        pbit     <= 1'b0;
                        stop_idx <= 1'b0;
                        stop_bad <= 1'b0;
                        all_low  <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_sample) begin
                     cnt      <= '0;
                     sh[bidx] <= rx;
                     all_low  <= all_low & ~rx;
                     if (bidx == last_idx) state <= par_on ? ST_PAR : ST_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_sample) begin
                     cnt     <= '0;
                     pbit    <= rx;
                     all_low <= all_low & ~rx;
                     state   <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (at_sample) begin
                     cnt <= '0;
                     if (final_stop) begin
                        done     <= 1'b1;
                        chr.data <= sh;
                        chr.perr <= par_on & (^sh ^ pbit ^ par_odd);
                        chr.ferr <= stop_bad | ~rx;
                        chr.brk  <= all_low & ~rx;
                        state    <= (all_low & ~rx) ? ST_BRKW : ST_IDLE;
                     end else begin
                        stop_idx <= 1'b1;
                        stop_bad <= stop_bad | ~rx;
                        all_low  <= all_low & ~rx;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_BRKW: begin
                  if (rx) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/srx_hold.sv
module srx_hold
   import srx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      done,
   input  srx_char_t chr,
   input  logic      out_ready,
   output logic      out_valid,
   output srx_char_t out_chr,
   output logic      out_ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chr   <= '0;
         out_ovr   <= 1'b0;
      end else if (done) begin
         out_chr   <= chr;
         out_ovr   <= out_valid & ~out_ready;
         out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
   import srx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rx_line,
   input  logic [1:0] cfg_len,
   input  logic [1:0] cfg_par,
   input  logic       cfg_stop2,
   input  logic       out_ready,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_perr,
   output logic       out_ferr,
   output logic       out_brk,
   output logic       out_ovr
);
   generate
      if ((OVS < 4) || (OVS % 2 != 0)) begin : g_bad_ovs
         $error("async_char_rx: OVS must be even and at least 4");
      end
      if (DATA_W != 8) begin : g_bad_width
         $error("async_char_rx: data width must be 8");
      end
   endgenerate

   logic      rx_s;
   logic      done;
   srx_char_t fr_chr;
   srx_char_t hd_chr;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
   );

   srx_framer #(.OVS(OVS)) u_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
      .done(done), .chr(fr_chr)
   );

   srx_hold u_hold (
      .clk(clk), .rst_n(rst_n), .done(done), .chr(fr_chr),
      .out_ready(out_ready), .out_valid(out_valid),
      .out_chr(hd_chr), .out_ovr(out_ovr)
   );

   assign out_data = hd_chr.data;
   assign out_perr = hd_chr.perr;
   assign out_ferr = hd_chr.ferr;
   assign out_brk  = hd_chr.brk;
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick16,
   input logic [1:0] cfg_len,
   input logic [1:0] cfg_par,
   input logic       out_ready,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic       out_perr,
   input logic       out_ferr,
   input logic       out_brk,
   input logic       out_ovr
);
   // R10
   hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid);

   // R10
   payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=>
         ($stable(out_data) && $stable(out_perr) && $stable(out_ferr) && $stable(out_brk)) || out_ovr);

   // R3
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data >> ({2'b00, cfg_len} + 4'd5)) == 8'd0));

   // R7
   break_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_brk |-> out_ferr && (out_data == 8'd0));

   // R9
   ovr_over_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_ovr) |-> $past(out_valid));

   // R4
   no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && ((cfg_par == 2'b00) || (cfg_par == 2'b11)) |-> !out_perr);

   // R2
   after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(tick16, 2));
endmodule

bind async_char_rx srx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len),
   .cfg_par(cfg_par), .out_ready(out_ready), .out_valid(out_valid),
   .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr),
   .out_brk(out_brk), .out_ovr(out_ovr)
);

// File: tb/tb_async_char_rx.sv
`timescale 1ns/1ps
module tb_async_char_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] cfg_len = 2'b11;
   logic [1:0] cfg_par = 2'b00;
   logic       cfg_stop2 = 1'b0;
   logic       out_ready = 1'b0;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_perr, out_ferr, out_brk, out_ovr;

   int n_tests = 0;
   int n_fail  = 0;
   int n_print = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   async_char_rx dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk),
      .out_ovr(out_ovr)
   );

   // tick every 4 clocks: one bit period is 64 clocks
   int divcnt = 0;
   always @(negedge clk) begin
      tick16 <= (divcnt == 3);
      divcnt  = (divcnt + 1) % 4;
   end

   // ---------------- behavioural reference model ----------------
   bit m_s1 = 1, m_s2 = 1;
   int mode = 0;       // 0 seek, 1 in frame, 2 waiting after break
   int tc = 0;         // ticks since start edge seen
   int mbits[0:11];
   bit pend = 0;
   logic [7:0] p_data; bit p_perr, p_ferr, p_brk;
   bit e_valid = 0, e_perr = 0, e_ferr = 0, e_brk = 0, e_ovr = 0;
   logic [7:0] e_data = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; mode = 0; tc = 0; pend = 0;
         e_valid = 0; e_perr = 0; e_ferr = 0; e_brk = 0; e_ovr = 0; e_data = 0;
      end else begin
         bit line;
         int len, np, ns, nb, ones;
         if (pend) begin
            e_ovr = e_valid && !out_ready;
            e_valid = 1; e_data = p_data; e_perr = p_perr; e_ferr = p_ferr; e_brk = p_brk;
         end else if (e_valid && out_ready) begin
            e_valid = 0;
         end
         pend = 0;
         line = m_s2;
         len = int'(cfg_len) + 5;
         np  = (cfg_par == 2'b01 || cfg_par == 2'b10) ? 1 : 0;
         ns  = cfg_stop2 ? 2 : 1;
         nb  = len + np + ns;
         if (tick16) begin
            if (mode == 0) begin
               if (!line) begin mode = 1; tc = 0; end
            end else if (mode == 2) begin
               if (line) mode = 0;
            end else begin
               tc = tc + 1;
               if (tc == 8) begin
                  if (line) mode = 0;
               end else if (tc > 8 && (tc - 8) % 16 == 0) begin
                  int k;
                  k = (tc - 8) / 16;
                  mbits[k-1] = int'(line);
                  if (k == nb) begin
                     bit allz;
                     p_data = 0; ones = 0; allz = 1; p_ferr = 0;
                     for (int i = 0; i < nb; i++) if (mbits[i] != 0) allz = 0;
                     for (int i = 0; i < len; i++) begin
                        p_data[i] = mbits[i][0];
                        ones += mbits[i];
                     end
                     p_perr = 0;
                     if (np == 1) p_perr = (((ones + mbits[len]) % 2) != ((cfg_par == 2'b10) ? 1 : 0));
                     for (int j = 0; j < ns; j++) if (mbits[len+np+j] == 0) p_ferr = 1;
                     p_brk = allz;
                     pend = 1;
                     mode = allz ? 2 : 0;
                  end
               end
            end
         end
         m_s2 = m_s1;
         m_s1 = rx_line;
      end
   end

   // per-cycle comparison against the model (R10 handshake, all fields)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit bad;
         n_tests++;
         bad = (out_valid !== e_valid);
         if (e_valid)
            bad = bad || (out_data !== e_data) || (out_perr !== e_perr) ||
                  (out_ferr !== e_ferr) || (out_brk !== e_brk) || (out_ovr !== e_ovr);
         if (bad) begin
            n_fail++;
            if (n_print < 10) begin
               n_print++;
               $display("FAIL R10 model cycle: got v=%0b d=%h p%0b f%0b b%0b o%0b exp v=%0b d=%h p%0b f%0b b%0b o%0b",
                        out_valid, out_data, out_perr, out_ferr, out_brk, out_ovr,
                        e_valid, e_data, e_perr, e_ferr, e_brk, e_ovr);
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send_bit(input logic b);
      rx_line = b;
      repeat (64) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input int len, input bit has_par,
                            input logic pbit, input logic s1, input logic s2, input int nstop);
      send_bit(1'b0);
      for (int i = 0; i < len; i++) send_bit(d[i]);
      if (has_par) send_bit(pbit);
      send_bit(s1);
      if (nstop == 2) send_bit(s2);
      send_bit(1'b1);
   endtask

   task automatic check(input string tag, input bit ok, input string msg);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s", tag, msg);
      end
   endtask

   task automatic expect_char(input string tag, input logic [7:0] d, input bit p,
                              input bit f, input bit b, input bit o);
      check(tag, out_valid === 1'b1 && out_data === d && out_perr === p &&
                 out_ferr === f && out_brk === b && out_ovr === o,
            $sformatf("got v=%0b d=%h p%0b f%0b b%0b o%0b exp v=1 d=%h p%0b f%0b b%0b o%0b",
                      out_valid, out_data, out_perr, out_ferr, out_brk, out_ovr, d, p, f, b, o));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_none(input string tag);
      check(tag, out_valid === 1'b0, $sformatf("got valid=%0b exp valid=0", out_valid));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired got running exp finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", out_valid === 0 && out_perr === 0 && out_ferr === 0 && out_brk === 0 && out_ovr === 0,
            $sformatf("got v%0b p%0b f%0b b%0b o%0b exp all 0", out_valid, out_perr, out_ferr, out_brk, out_ovr));
      repeat (200) @(negedge clk);
      expect_none("R1");

      // R2 R3: 8 bits, no parity, one stop
      cfg_len = 2'b11; cfg_par = 2'b00; cfg_stop2 = 0;
      send_char(8'hA5, 8, 0, 0, 1, 1, 1);
      expect_char("R2", 8'hA5, 0, 0, 0, 0);

      // R3 R4: 5 bits even parity, correct parity bit
      cfg_len = 2'b00; cfg_par = 2'b01;
      send_char(8'h13, 5, 1, 1'b1, 1, 1, 1);
      expect_char("R3", 8'h13, 0, 0, 0, 0);
      // R4 wrong parity bit
      send_char(8'h13, 5, 1, 1'b0, 1, 1, 1);
      expect_char("R4", 8'h13, 1, 0, 0, 0);

      // R4 7 bits odd parity; upper bit of input ignored by R3
      cfg_len = 2'b10; cfg_par = 2'b10;
      send_char(8'hD5, 7, 1, 1'b1, 1, 1, 1);
      expect_char("R3", 8'h55, 0, 0, 0, 0);
      send_char(8'h55, 7, 1, 1'b0, 1, 1, 1);
      expect_char("R4", 8'h55, 1, 0, 0, 0);

      // R6 6 bits, two stops, second stop low
      cfg_len = 2'b01; cfg_par = 2'b11; cfg_stop2 = 1;
      send_char(8'h2A, 6, 0, 0, 1, 0, 2);
      repeat (128) @(negedge clk);
      expect_char("R6", 8'h2A, 0, 1, 0, 0);
      send_char(8'h15, 6, 0, 0, 1, 1, 2);
      expect_char("R6", 8'h15, 0, 0, 0, 0);

      // R6 single stop low
      cfg_len = 2'b11; cfg_par = 2'b00; cfg_stop2 = 0;
      send_char(8'h7E, 8, 0, 0, 0, 1, 1);
      repeat (128) @(negedge clk);
      expect_char("R6", 8'h7E, 0, 1, 0, 0);

      // R5 false start: short low pulse
      rx_line = 1'b0;
      repeat (16) @(negedge clk);
      rx_line = 1'b1;
      repeat (1000) @(negedge clk);
      expect_none("R5");
      send_char(8'h5A, 8, 0, 0, 1, 1, 1);
      expect_char("R5", 8'h5A, 0, 0, 0, 0);

      // R7 break
      rx_line = 1'b0;
      repeat (64 * 14) @(negedge clk);
      expect_char("R7", 8'h00, 0, 1, 1, 0);
      // R8 still low: no new character
      repeat (64 * 6) @(negedge clk);
      expect_none("R8");
      rx_line = 1'b1;
      repeat (128) @(negedge clk);
      send_char(8'h3C, 8, 0, 0, 1, 1, 1);
      expect_char("R8", 8'h3C, 0, 0, 0, 0);

      // R9 overrun
      send_char(8'h11, 8, 0, 0, 1, 1, 1);
      send_char(8'h22, 8, 0, 0, 1, 1, 1);
      expect_char("R9", 8'h22, 0, 0, 0, 1);
      send_char(8'h33, 8, 0, 0, 1, 1, 1);
      expect_char("R9", 8'h33, 0, 0, 0, 0);

      // R10 held while not ready
      send_char(8'hC3, 8, 0, 0, 1, 1, 1);
      repeat (300) @(negedge clk);
      check("R10", out_valid === 1'b1 && out_data === 8'hC3,
            $sformatf("got v=%0b d=%h exp v=1 d=c3", out_valid, out_data));
      expect_char("R10", 8'hC3, 0, 0, 0, 0);
      expect_none("R10");

      repeat (20) @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule